// File: doc/BRIEF.md
# Binary Register-Protocol Slave Responder

This block is the responding end of a compact binary request/response protocol carried as a byte stream. A request frame arrives one byte at a time over a valid/ready interface with start-of-frame and end-of-frame markers. The block collects the whole frame, checks it, carries out the request, and then sends a response frame of the same shape over a second valid/ready byte interface.

Two operations are served. One writes a single 16-bit word into a small internal holding-register array and echoes the address and the stored word. The other is a loopback test that returns its two operands untouched. Every response swaps the two 4-bit CPU identifiers, so the reply is addressed back to the requester. Any frame that is malformed, or that names another operation or an address outside the array, gives a one-cycle error pulse and no response.

The block handles one request at a time: while a request is being checked, executed or answered, the input side is not ready.

Top module: `regproto_slave`

## Requirements
- R1: After reset, `out_valid` and `err_pulse` are 0 and `in_ready` is 1.
- R2: A frame is nine bytes: length low, length high, main code, sub code, CPU byte, operand A low, operand A high, operand B low, operand B high. The first byte carries `in_sof`/`out_sof` and the ninth carries `in_eof`/`out_eof`; no other byte carries either marker.
- R3: A request with length 0x0007, main code 0x20 and sub code 0x08 is answered with 0x07, 0x00, 0x20, 0x08, the swapped CPU byte, then operands A and B unchanged, low byte first. `out_valid` rises after the first clock edge following the edge that accepts the last request byte.
- R4: A request with length 0x0007, main code 0x20, sub code 0x06 and operand A below 64 stores operand B into holding register A. The response is 0x07, 0x00, 0x20, 0x06, the swapped CPU byte, operand A, then the word read back from register A, each low byte first. `out_valid` rises after the third clock edge following the edge that accepts the last request byte.
- R5: The response CPU byte is the request CPU byte with its high and low nibbles exchanged.
- R6: A length other than 0x0007, a main code other than 0x20, a sub code other than 0x06 or 0x08, or a write address of 64 or more produces no response and raises `err_pulse` for exactly one cycle, after the first clock edge following the edge that accepts the last request byte.
- R7: A frame that ends with `in_eof` before its ninth byte, or whose ninth byte lacks `in_eof`, is handled as in R6. Bytes accepted while no frame is open and without `in_sof` are ignored; a byte with `in_sof` inside an open frame discards it and starts a new one.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_sof` and `out_eof` hold their values on the next cycle.
- R9: `in_ready` is 0 from the edge that accepts the last request byte until the response's last byte is accepted or the error pulse is issued, and is 1 again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request byte offered |
| in_ready | output | 1 | Request byte can be accepted |
| in_data | input | 8 | Request byte |
| in_sof | input | 1 | Request byte is the first of a frame |
| in_eof | input | 1 | Request byte is the last of a frame |
| out_valid | output | 1 | Response byte offered |
| out_ready | input | 1 | Downstream accepts the response byte |
| out_data | output | 8 | Response byte |
| out_sof | output | 1 | Response byte is the first of a frame |
| out_eof | output | 1 | Response byte is the last of a frame |
| err_pulse | output | 1 | One-cycle flag for a rejected request |

## Verification
Taking the edge that accepts the final request byte as edge zero, a loopback response and an error pulse become visible after edge one, and a write response after edge three because the stored word is read back from the array. The bench records that edge number when it offers the last byte, records the cycle in which `out_valid` first rises or `err_pulse` appears, and compares the difference against these fixed latencies for every request. Response bytes are captured only on handshakes, with inputs driven and outputs sampled on the falling clock edge, and stalled bytes are compared across the cycle that follows each refused transfer.

// File: rtl/rp_pkg.sv
`timescale 1ns/1ps
package rp_pkg;
  localparam int FRAME_LEN = 9;
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [15:0] LEN_FIELD = 16'h0007;
  localparam logic [7:0] MAIN_CODE = 8'h20;
  localparam logic [7:0] SUB_WRITE = 8'h06;
  localparam logic [7:0] SUB_LOOP = 8'h08;

  typedef struct packed {
    logic [15:0] len;
    logic [7:0]  main_code;
    logic [7:0]  sub_code;
    logic [7:0]  cpu;
    logic [15:0] opa;
    logic [15:0] opb;
  } req_t;

  typedef struct packed {
    logic [7:0]  sub_code;
    logic [7:0]  cpu;
    logic [15:0] opa;
    logic [15:0] opb;
  } rsp_t;
endpackage

// File: rtl/rp_rx_collect.sv
`timescale 1ns/1ps
module rp_rx_collect
  import rp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic [7:0] data,
  input  logic       sof,
  input  logic       eof,
  output logic       done,
  output logic       bad,
  output req_t       req
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic [7:0]       bytes_q [FRAME_LEN];
  logic [IDX_W-1:0] idx_q;
  logic             open_q;
  logic             done_q;
  logic             bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      open_q <= 1'b0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (sof) begin
          bytes_q[0] <= data;
          idx_q      <= IDX_W'(1);
          open_q     <= !eof;
          done_q     <= eof;
          bad_q      <= eof;
        end else if (open_q) begin
          bytes_q[idx_q] <= data;
          idx_q          <= idx_q + 1'b1;
          if (eof || idx_q == LAST) begin
            done_q <= 1'b1;
            open_q <= 1'b0;
            bad_q  <= !(eof && idx_q == LAST);
          end
        end
      end
    end
  end

  assign done = done_q;
  assign bad  = bad_q;

  always_comb begin
    req.len       = {bytes_q[1], bytes_q[0]};
    req.main_code = bytes_q[2];
    req.sub_code  = bytes_q[3];
    req.cpu       = bytes_q[4];
    req.opa       = {bytes_q[6], bytes_q[5]};
    req.opb       = {bytes_q[8], bytes_q[7]};
  end

  // R9
  no_accept_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !accept);

  // R7
  idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    open_q |-> (idx_q <= LAST));
endmodule

// File: rtl/rp_regfile.sv
`timescale 1ns/1ps
module rp_regfile #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/rp_tx_frame.sv
`timescale 1ns/1ps
module rp_tx_frame
  import rp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  rsp_t       payload,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       last_ack
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  rsp_t             pl_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;
  logic [7:0]       data_q;
  logic             sof_q;
  logic             eof_q;

  function automatic logic [7:0] pick(input logic [IDX_W-1:0] k, input rsp_t p);
    case (k)
      IDX_W'(0): pick = LEN_FIELD[7:0];
      IDX_W'(1): pick = LEN_FIELD[15:8];
      IDX_W'(2): pick = MAIN_CODE;
      IDX_W'(3): pick = p.sub_code;
      IDX_W'(4): pick = p.cpu;
      IDX_W'(5): pick = p.opa[7:0];
      IDX_W'(6): pick = p.opa[15:8];
      IDX_W'(7): pick = p.opb[7:0];
      IDX_W'(8): pick = p.opb[15:8];
      default:   pick = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      data_q  <= 8'h00;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
    end else if (start) begin
      pl_q    <= payload;
      valid_q <= 1'b1;
      idx_q   <= '0;
      data_q  <= pick('0, payload);
      sof_q   <= 1'b1;
      eof_q   <= 1'b0;
    end else if (valid_q && out_ready) begin
      if (idx_q == LAST) begin
        valid_q <= 1'b0;
        sof_q   <= 1'b0;
        eof_q   <= 1'b0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        data_q <= pick(idx_q + 1'b1, pl_q);
        sof_q  <= 1'b0;
        eof_q  <= (idx_q + 1'b1 == LAST);
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_sof   = sof_q;
  assign out_eof   = eof_q;
  assign last_ack  = valid_q && out_ready && eof_q;

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !out_valid);

  // R2
  first_has_sof_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_sof && !out_eof));
endmodule

// File: rtl/regproto_slave.sv
`timescale 1ns/1ps
module regproto_slave
  import rp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       err_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [16:0] DEPTH_W = 17'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOAD, S_SEND} state_t;

  state_t      state_q;
  logic        accept;
  logic        rx_done;
  logic        rx_bad;
  req_t        req;
  logic        is_write;
  logic        is_loop;
  logic        req_ok;
  logic        we;
  logic [15:0] rd_word;
  logic        tx_start;
  logic        tx_last;
  rsp_t        rsp;
  logic        err_q;

  assign in_ready = (state_q == S_IDLE) && !rx_done;
  assign accept   = in_valid && in_ready;

  rp_rx_collect u_rx (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .data   (in_data),
    .sof    (in_sof),
    .eof    (in_eof),
    .done   (rx_done),
    .bad    (rx_bad),
    .req    (req)
  );

  always_comb begin
    is_write = (req.sub_code == SUB_WRITE);
    is_loop  = (req.sub_code == SUB_LOOP);
    req_ok   = !rx_bad && (req.len == LEN_FIELD) && (req.main_code == MAIN_CODE) &&
               (is_loop || (is_write && ({1'b0, req.opa} < DEPTH_W)));
  end

  assign we = rx_done && req_ok && is_write;

  rp_regfile #(.DEPTH(DEPTH), .WIDTH(16)) u_regs (
    .clk   (clk),
    .we    (we),
    .waddr (req.opa[AW-1:0]),
    .wdata (req.opb),
    .raddr (req.opa[AW-1:0]),
    .rdata (rd_word)
  );

  assign tx_start = (rx_done && req_ok && is_loop) || (state_q == S_LOAD);

  always_comb begin
    rsp.sub_code = req.sub_code;
    rsp.cpu      = {req.cpu[3:0], req.cpu[7:4]};
    rsp.opa      = req.opa;
    rsp.opb      = (state_q == S_LOAD) ? rd_word : req.opb;
  end

  rp_tx_frame u_tx (
    .clk       (clk),
    .rst       (rst),
    .start     (tx_start),
    .payload   (rsp),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .last_ack  (tx_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      err_q   <= 1'b0;
    end else begin
      err_q <= rx_done && !req_ok;
      case (state_q)
        S_IDLE:  if (rx_done && req_ok) state_q <= is_write ? S_FETCH : S_SEND;
        S_FETCH: state_q <= S_LOAD;
        S_LOAD:  state_q <= S_SEND;
        S_SEND:  if (tx_last) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign err_pulse = err_q;

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);

  // R6
  err_no_response_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !out_valid);

  // R9
  busy_while_sending_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R9
  done_only_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> (state_q == S_IDLE && !out_valid));
endmodule

// File: tb/sim_regproto_slave.sv
`timescale 1ns/1ps
module sim_regproto_slave;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;
  logic       out_sof;
  logic       out_eof;
  logic       err_pulse;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit bp_en = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign out_ready = !bp_en || ((cyc % 3) != 0);

  regproto_slave #(.DEPTH(64)) u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .err_pulse(err_pulse)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // response monitor: everything sampled on the falling edge
  logic [7:0] rb [16];
  bit         rs [16];
  bit         re [16];
  int  rcnt = 0;
  int  first_cyc = 0;
  int  err_cnt = 0;
  int  err_cyc = 0;
  int  last_acc = 0;
  bit  prev_v = 1'b0;
  bit  stall_pend = 1'b0;
  logic [7:0] stall_d;
  bit  stall_s, stall_e;

  always @(negedge clk) begin
    if (!rst) begin
      if (stall_pend)
        chk(out_valid && out_data == stall_d && out_sof == stall_s && out_eof == stall_e,
            "R8", "stalled byte changed", {out_valid, out_data}, {1'b1, stall_d});
      stall_pend = out_valid && !out_ready;
      stall_d = out_data; stall_s = out_sof; stall_e = out_eof;
      if (out_valid && !prev_v) first_cyc = cyc;
      prev_v = out_valid;
      if (out_valid) chk(!in_ready, "R9", "in_ready during response", in_ready, 0);
      if (out_valid && out_ready && rcnt < 16) begin
        rb[rcnt] = out_data; rs[rcnt] = out_sof; re[rcnt] = out_eof;
        rcnt++;
      end
      if (err_pulse) begin err_cnt++; err_cyc = cyc; end
    end
  end

  logic [7:0] fb [16];

  task automatic fill(input logic [15:0] len, input logic [7:0] mc, input logic [7:0] sc,
                      input logic [7:0] cpu, input logic [15:0] a, input logic [15:0] b);
    fb[0] = len[7:0]; fb[1] = len[15:8]; fb[2] = mc; fb[3] = sc; fb[4] = cpu;
    fb[5] = a[7:0]; fb[6] = a[15:8]; fb[7] = b[7:0]; fb[8] = b[15:8];
  endtask

  task automatic put_byte(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    while (!in_ready) @(negedge clk);
    last_acc = cyc + 1;
  endtask

  task automatic send_raw(input int n, input int eof_at, input bit with_sof);
    for (int i = 0; i < n; i++) put_byte(fb[i], with_sof && i == 0, i == eof_at);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic do_rsp(input string rq, input logic [7:0] sc, input logic [7:0] cpu,
                        input logic [15:0] a, input logic [15:0] b_exp, input int lat);
    logic [7:0] e [9];
    int eb, t, bad_i;
    bit flags_ok;
    e[0] = 8'h07; e[1] = 8'h00; e[2] = 8'h20; e[3] = sc; e[4] = {cpu[3:0], cpu[7:4]};
    e[5] = a[7:0]; e[6] = a[15:8]; e[7] = b_exp[7:0]; e[8] = b_exp[15:8];
    rcnt = 0; eb = err_cnt;
    send_raw(9, 8, 1'b1);
    t = 0;
    while (rcnt < 9 && t < 200) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(rcnt == 9, rq, "response byte count", rcnt, 9);
    bad_i = -1;
    flags_ok = 1'b1;
    for (int i = 0; i < 9; i++) begin
      if (bad_i < 0 && rb[i] !== e[i]) bad_i = i;
      if (rs[i] != (i == 0) || re[i] != (i == 8)) flags_ok = 1'b0;
    end
    if (bad_i >= 0) chk(1'b0, rq, $sformatf("response byte %0d", bad_i), rb[bad_i], e[bad_i]);
    else chk(1'b1, rq, "response bytes", 0, 0);
    chk(flags_ok, "R2", "response sof/eof placement", flags_ok, 1);
    chk(first_cyc == last_acc + lat, rq, "response latency", first_cyc - last_acc, lat);
    chk(err_cnt == eb, rq, "unexpected error pulse", err_cnt - eb, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after response", in_ready, 1);
  endtask

  task automatic do_err(input string rq, input int n, input int eof_at);
    int eb;
    rcnt = 0; eb = err_cnt;
    send_raw(n, eof_at, 1'b1);
    repeat (8) @(negedge clk);
    chk(err_cnt == eb + 1, rq, "error pulse count", err_cnt - eb, 1);
    chk(err_cyc == last_acc + 1, rq, "error latency", err_cyc - last_acc, 1);
    chk(rcnt == 0, rq, "response bytes on error", rcnt, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after error", in_ready, 1);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int eb;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(err_pulse == 1'b0, "R1", "err_pulse after reset", err_pulse, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R3 R5: basic loopback with the conventional test pattern
    fill(16'h0007, 8'h20, 8'h08, 8'h12, 16'h0000, 16'hAAAA);
    do_rsp("R3", 8'h08, 8'h12, 16'h0000, 16'hAAAA, 1);

    // R3 R5 R8: loopback sweep of CPU nibbles and operands, with backpressure on odd runs
    for (int i = 0; i < 16; i++) begin
      logic [7:0] cpu;
      logic [15:0] a, b;
      cpu = {4'(i), 4'(15 - i)};
      a = 16'(i * 16'h1111);
      b = 16'(i * 16'h0F0F) ^ 16'h5A5A;
      bp_en = i[0];
      fill(16'h0007, 8'h20, 8'h08, cpu, a, b);
      do_rsp("R5", 8'h08, cpu, a, b, 1);
    end

    // R4: write every holding register
    for (int a = 0; a < 64; a++) begin
      d = 16'(a * 16'h0407 + 16'h1234);
      bp_en = (a % 4) == 1;
      fill(16'h0007, 8'h20, 8'h06, 8'h3C, 16'(a), d);
      do_rsp("R4", 8'h06, 8'h3C, 16'(a), d, 3);
    end
    // R4: overwrite a subset with new data
    for (int a = 0; a < 64; a += 7) begin
      d = ~16'(a * 16'h0407 + 16'h1234);
      bp_en = 1'b1;
      fill(16'h0007, 8'h20, 8'h06, 8'hA5, 16'(a), d);
      do_rsp("R4", 8'h06, 8'hA5, 16'(a), d, 3);
    end
    bp_en = 1'b0;

    // R6: rejected requests
    fill(16'h0006, 8'h20, 8'h08, 8'h11, 16'h0000, 16'h1111); do_err("R6", 9, 8);
    fill(16'h0107, 8'h20, 8'h08, 8'h11, 16'h0000, 16'h1111); do_err("R6", 9, 8);
    fill(16'h0007, 8'h21, 8'h08, 8'h11, 16'h0000, 16'h1111); do_err("R6", 9, 8);
    fill(16'h0007, 8'h00, 8'h06, 8'h11, 16'h0001, 16'h1111); do_err("R6", 9, 8);
    for (int s = 0; s < 16; s++) begin
      if (s != 6 && s != 8) begin
        fill(16'h0007, 8'h20, 8'(s), 8'h11, 16'h0000, 16'h1111);
        do_err("R6", 9, 8);
      end
    end
    fill(16'h0007, 8'h20, 8'h06, 8'h11, 16'd64, 16'h1111);  do_err("R6", 9, 8);
    fill(16'h0007, 8'h20, 8'h06, 8'h11, 16'h00FF, 16'h1111); do_err("R6", 9, 8);
    fill(16'h0007, 8'h20, 8'h06, 8'h11, 16'h0100, 16'h1111); do_err("R6", 9, 8);
    fill(16'h0007, 8'h20, 8'h06, 8'h11, 16'hFFFF, 16'h1111); do_err("R6", 9, 8);
    // R6: boundary address just inside the array still works
    fill(16'h0007, 8'h20, 8'h06, 8'h11, 16'd63, 16'hBEEF);
    do_rsp("R6", 8'h06, 8'h11, 16'd63, 16'hBEEF, 3);

    // R7: framing faults
    fill(16'h0007, 8'h20, 8'h08, 8'h11, 16'h0000, 16'h1111);
    do_err("R7", 8, 7);
    do_err("R7", 9, 99);
    do_err("R7", 1, 0);
    do_err("R7", 5, 4);

    // R7: stray bytes without a start marker are ignored
    eb = err_cnt; rcnt = 0;
    fill(16'h0007, 8'h20, 8'h08, 8'h11, 16'h0000, 16'h1111);
    send_raw(9, 8, 1'b0);
    repeat (8) @(negedge clk);
    chk(err_cnt == eb, "R7", "error from stray bytes", err_cnt - eb, 0);
    chk(rcnt == 0, "R7", "response from stray bytes", rcnt, 0);
    fill(16'h0007, 8'h20, 8'h08, 8'h77, 16'h1357, 16'h2468);
    do_rsp("R7", 8'h08, 8'h77, 16'h1357, 16'h2468, 1);

    // R7: a new start marker restarts an open frame
    fill(16'h0007, 8'h20, 8'h06, 8'h99, 16'h0005, 16'hDEAD);
    send_raw(4, 99, 1'b1);
    fill(16'h0007, 8'h20, 8'h08, 8'hC3, 16'h0000, 16'hAAAA);
    do_rsp("R7", 8'h08, 8'hC3, 16'h0000, 16'hAAAA, 1);

    // R4: the restarted write did not land; register 5 still echoes a fresh write
    fill(16'h0007, 8'h20, 8'h06, 8'h01, 16'h0005, 16'h0F0F);
    do_rsp("R4", 8'h06, 8'h01, 16'h0005, 16'h0F0F, 3);

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule